// File: doc/BRIEF.md
# Load/Store Unit for a 64-bit Register Machine

This block executes the memory-access instructions of a 64-bit register machine whose memory is addressed by byte. For each accepted instruction it adds a sign-extended 16-bit displacement to an integer base value. The low three bits of that effective address, together with the access width taken from the opcode, give a byte-lane mask for one 64-bit word. The block then makes a single read or write request on a word-wide memory port and keeps that request on the port until memory answers with ready.

Store data is trimmed to the access width and moved into the selected byte lanes. On a load, the addressed bytes are taken out of the returned word, zero-extended to 64 bits, and presented as a one-cycle writeback together with the destination index and a flag that marks a floating-point destination. An access whose bytes do not all fit inside one aligned 8-byte word never reaches memory. It raises a one-cycle error pulse instead.

Top module: `lsu_core`

## Requirements
- R1: The effective address is issue_base plus issue_imm sign-extended to 64 bits. mem_addr is that address with its three low bits forced to zero.
- R2: The access width comes from the two low opcode bits (00 = 1 byte, 01 = 2, 10 = 4, 11 = 8). The two floating-point opcodes always use 8 bytes. mem_be has exactly that many consecutive bits set, starting at bit (effective address mod 8).
- R3: The store opcodes are 0x10 to 0x13 (integer) and 0x2b (floating point). A store drives mem_we=1. mem_wdata carries the low bytes of issue_data in the enabled lanes and zero in every other lane.
- R4: The load opcodes are 0x0c to 0x0f (integer) and 0x2a (floating point). A load drives mem_we=0. wb_data is the addressed bytes of mem_rdata, with the byte at the effective address in bits 7:0, and every higher bit is zero.
- R5: If (effective address mod 8) plus the width is greater than 8, no request is made. misalign_err is high for exactly the cycle after acceptance, and neither done nor wb_valid rises.
- R6: A request appears in the cycle after acceptance. mem_req, mem_we, mem_addr, mem_be and mem_wdata stay unchanged until a cycle in which mem_ready is high. In the next cycle mem_req is low and done is high for one cycle.
- R7: An integer load whose destination index is 0 still performs its read and pulses done, but wb_valid stays low.
- R8: A load with opcode 0x2a writes back with wb_fp=1, for every index including 0. Integer loads write back with wb_fp=0. wb_valid and wb_idx come in the same cycle as done.
- R9: An opcode outside the ten listed above is ignored: it produces no request, no done and no error.
- R10: While reset is high, busy, mem_req, done, wb_valid and misalign_err are all low.
- R11: While busy is high, issue_valid is ignored. The outstanding request does not change, and no second request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| issue_op | input | 6 | Opcode |
| issue_base | input | 64 | Integer base register value |
| issue_imm | input | 16 | Signed displacement |
| issue_data | input | 64 | Store source value (integer or floating) |
| issue_idx | input | 5 | Register index of the load destination |
| busy | output | 1 | Request outstanding, issue not accepted |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Word-aligned address |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Write data placed in lanes |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 64 | Read word, valid with mem_ready |
| wb_valid | output | 1 | Writeback pulse |
| wb_fp | output | 1 | Writeback targets the floating-point file |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Zero-extended load value |
| done | output | 1 | Instruction completed |
| misalign_err | output | 1 | Access crossed an 8-byte word |

## Verification
The bench runs every memory opcode at every byte offset, with positive and negative displacements and a large base. This exposes a design that shifts lanes the wrong way, forgets to clear bits above the access width, or drops the sign of the displacement. Every combination of offset and width that crosses a word boundary must produce only the error pulse, so a design that tests the boundary with >= instead of >, or that still issues the access, is caught at once. Memory answers after zero to two wait cycles while the bench watches the request, which exposes a request that changes or drops before ready. A design that writes back to integer register 0, or that suppresses the floating-point writeback to index 0, fails the writeback-flag checks. A design that accepts a new instruction while one is outstanding, or acts on an unlisted opcode, shows up as an unexpected request or done pulse.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      valid;
    logic      is_store;
    logic      is_fp;
    acc_size_e size;
  } acc_kind_t;

  localparam logic [5:0] OP_LD_FIRST = 6'h0c;
  localparam logic [5:0] OP_LD_LAST  = 6'h0f;
  localparam logic [5:0] OP_ST_FIRST = 6'h10;
  localparam logic [5:0] OP_ST_LAST  = 6'h13;
  localparam logic [5:0] OP_FP_LOAD  = 6'h2a;
  localparam logic [5:0] OP_FP_STORE = 6'h2b;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [5:0] op,
  output acc_kind_t  kind
);

  always_comb begin
    kind = '0;
    if (op >= OP_LD_FIRST && op <= OP_LD_LAST) begin
      kind.valid = 1'b1;
      kind.size  = acc_size_e'(op[1:0]);
    end else if (op >= OP_ST_FIRST && op <= OP_ST_LAST) begin
      kind.valid    = 1'b1;
      kind.is_store = 1'b1;
      kind.size     = acc_size_e'(op[1:0]);
    end else if (op == OP_FP_LOAD) begin
      kind.valid = 1'b1;
      kind.is_fp = 1'b1;
      kind.size  = SZ_DBL;
    end else if (op == OP_FP_STORE) begin
      kind.valid    = 1'b1;
      kind.is_store = 1'b1;
      kind.is_fp    = 1'b1;
      kind.size     = SZ_DBL;
    end
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16,
  parameter int LANES  = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFF_W-1:0]  offset,
  output logic [LANES-1:0]  be,
  output logic              misalign
);

  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] eff;
  logic [OFF_W:0]    nbytes;
  logic [OFF_W:0]    span;

  always_comb begin
    imm_ext   = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    eff       = base + imm_ext;
    offset    = eff[OFF_W-1:0];
    word_addr = {eff[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    nbytes    = (OFF_W+1)'(1) << size;
    span      = {1'b0, offset} + nbytes;
    misalign  = span > (OFF_W+1)'(LANES);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = ((OFF_W+1)'(g) >= {1'b0, offset}) && ((OFF_W+1)'(g) < span);
  end

endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] st_src,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [OFF_W-1:0]  st_off,
  input  acc_size_e         st_size,
  input  logic [OFF_W-1:0]  ld_off,
  input  acc_size_e         ld_size,
  output logic [DATA_W-1:0] st_word,
  output logic [DATA_W-1:0] ld_value
);

  logic [DATA_W-1:0] st_trim;
  logic [DATA_W-1:0] ld_shift;
  logic [OFF_W:0]    st_n;
  logic [OFF_W:0]    ld_n;

  always_comb begin
    st_n     = (OFF_W+1)'(1) << st_size;
    ld_n     = (OFF_W+1)'(1) << ld_size;
    ld_shift = rd_word >> {ld_off, 3'b000};
    st_word  = st_trim << {st_off, 3'b000};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign st_trim[8*g +: 8]  = ((OFF_W+1)'(g) < st_n) ? st_src[8*g +: 8]   : 8'h00;
    assign ld_value[8*g +: 8] = ((OFF_W+1)'(g) < ld_n) ? ld_shift[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue_valid,
  input  logic [5:0]            issue_op,
  input  logic [ADDR_W-1:0]     issue_base,
  input  logic [IMM_W-1:0]      issue_imm,
  input  logic [DATA_W-1:0]     issue_data,
  input  logic [IDX_W-1:0]      issue_idx,
  output logic                  busy,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ready,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  wb_valid,
  output logic                  wb_fp,
  output logic [IDX_W-1:0]      wb_idx,
  output logic [DATA_W-1:0]     wb_data,
  output logic                  done,
  output logic                  misalign_err
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_kind_t         kind;
  logic [ADDR_W-1:0] ag_addr;
  logic [OFF_W-1:0]  ag_off;
  logic [LANES-1:0]  ag_be;
  logic              ag_mis;
  logic [DATA_W-1:0] st_word;
  logic [DATA_W-1:0] ld_value;
  logic              accept;

  logic              busy_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFF_W-1:0]  off_q;
  acc_size_e         size_q;
  logic              fp_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q;
  logic              err_q;
  logic              wbv_q;
  logic              wbfp_q;
  logic [IDX_W-1:0]  wbidx_q;
  logic [DATA_W-1:0] wbdata_q;

  lsu_decode u_dec (
    .op   (issue_op),
    .kind (kind)
  );

  lsu_agen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .LANES  (LANES)
  ) u_agen (
    .base      (issue_base),
    .imm       (issue_imm),
    .size      (kind.size),
    .word_addr (ag_addr),
    .offset    (ag_off),
    .be        (ag_be),
    .misalign  (ag_mis)
  );

  lsu_lanes #(
    .DATA_W (DATA_W)
  ) u_lanes (
    .st_src   (issue_data),
    .rd_word  (mem_rdata),
    .st_off   (ag_off),
    .st_size  (kind.size),
    .ld_off   (off_q),
    .ld_size  (size_q),
    .st_word  (st_word),
    .ld_value (ld_value)
  );

  assign accept = issue_valid && !busy_q && kind.valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      off_q    <= '0;
      size_q   <= SZ_BYTE;
      fp_q     <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      wbv_q    <= 1'b0;
      wbfp_q   <= 1'b0;
      wbidx_q  <= '0;
      wbdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wbv_q  <= 1'b0;
      if (!busy_q) begin
        if (accept) begin
          if (ag_mis) begin
            err_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            we_q    <= kind.is_store;
            addr_q  <= ag_addr;
            be_q    <= ag_be;
            wdata_q <= kind.is_store ? st_word : '0;
            off_q   <= ag_off;
            size_q  <= kind.size;
            fp_q    <= kind.is_fp;
            idx_q   <= issue_idx;
          end
        end
      end else if (mem_ready) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (!we_q) begin
          wbdata_q <= ld_value;
          wbidx_q  <= idx_q;
          wbfp_q   <= fp_q;
          wbv_q    <= fp_q || (idx_q != '0);
        end
      end
    end
  end

  assign busy         = busy_q;
  assign mem_req      = busy_q;
  assign mem_we       = we_q;
  assign mem_addr     = addr_q;
  assign mem_be       = be_q;
  assign mem_wdata    = wdata_q;
  assign wb_valid     = wbv_q;
  assign wb_fp        = wbfp_q;
  assign wb_idx       = wbidx_q;
  assign wb_data      = wbdata_q;
  assign done         = done_q;
  assign misalign_err = err_q;

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                mem_req,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_ready,
  input logic                wb_valid,
  input logic                wb_fp,
  input logic [IDX_W-1:0]    wb_idx,
  input logic                done,
  input logic                misalign_err
);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                 && $stable(mem_we) && $stable(mem_wdata)));

  a_r6_done: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> (done && !mem_req));

  a_r5_err_alone: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!done && !wb_valid && !mem_req));

  a_r2_be_width: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 $countones(mem_be) == 4 || $countones(mem_be) == 8));

  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  a_r8_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> done);

  a_r7_no_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_fp) |-> (wb_idx != '0));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind lsu_core lsu_core_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .IDX_W  (IDX_W)
) u_chk (.*);

// File: tb/lsu_core_bench.sv
`timescale 1ns/1ps
module lsu_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [5:0]  issue_op = '0;
  logic [63:0] issue_base = '0;
  logic [15:0] issue_imm = '0;
  logic [63:0] issue_data = '0;
  logic [4:0]  issue_idx = '0;
  logic        busy, mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        wb_valid, wb_fp, done, misalign_err;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [16];

  always #2 clk = ~clk;

  lsu_core u_lsu_core (
    .clk, .rst, .issue_valid, .issue_op, .issue_base, .issue_imm, .issue_data,
    .issue_idx, .busy, .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata,
    .mem_ready, .mem_rdata, .wb_valid, .wb_fp, .wb_idx, .wb_data, .done,
    .misalign_err
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int op_bytes(input logic [5:0] op);
    if (op == 6'h2a || op == 6'h2b) return 8;
    return 1 << op[1:0];
  endfunction

  function automatic logic op_store(input logic [5:0] op);
    return (op >= 6'h10 && op <= 6'h13) || op == 6'h2b;
  endfunction

  task automatic run_op(input logic [5:0] op, input logic [63:0] ea,
                        input logic [15:0] imm, input logic [63:0] data,
                        input logic [4:0] idx, input int waits);
    int          n   = op_bytes(op);
    int          off = int'(ea[2:0]);
    logic [63:0] mask = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
    logic [63:0] base = ea - {{48{imm[15]}}, imm};
    logic [7:0]  ebe = 8'(((16'd1 << n) - 16'd1) << off);
    logic [63:0] ewd = (data & mask) << (8 * off);
    logic [63:0] word;
    logic [63:0] eld;
    logic        fp = (op == 6'h2a);
    logic        ewb;
    issue_op = op; issue_base = base; issue_imm = imm;
    issue_data = data; issue_idx = idx; issue_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    if (off + n > 8) begin
      chk(misalign_err && !mem_req && !done && !wb_valid, "R5 misaligned pulse",
          {mem_req, done, wb_valid, misalign_err}, 64'h1);
      @(negedge clk);
      chk(!misalign_err && !mem_req && !done, "R5 misaligned single cycle",
          {misalign_err, mem_req, done}, 64'h0);
      return;
    end
    chk(mem_req && busy, "R6 request raised", {mem_req, busy}, 64'h3);
    chk(mem_addr == {ea[63:3], 3'b000}, "R1 word address", mem_addr, {ea[63:3], 3'b000});
    chk(mem_be == ebe, "R2 byte enables", 64'(mem_be), 64'(ebe));
    chk(mem_we == op_store(op), "R3/R4 write flag", 64'(mem_we), 64'(op_store(op)));
    if (op_store(op)) chk(mem_wdata == ewd, "R3 store lanes", mem_wdata, ewd);
    word = model[ea[6:3]];
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == {ea[63:3], 3'b000} && mem_be == ebe,
          "R6 request held", {mem_req, mem_be}, {1'b1, ebe});
    end
    mem_ready = 1'b1;
    mem_rdata = word;
    @(posedge clk);
    @(negedge clk);
    mem_ready = 1'b0;
    mem_rdata = '0;
    chk(done && !mem_req, "R6 done after ready", {done, mem_req}, 64'h2);
    if (op_store(op)) begin
      chk(!wb_valid, "R3 store no writeback", 64'(wb_valid), 64'h0);
      for (int b = 0; b < 8; b++)
        if (ebe[b]) word[8*b +: 8] = ewd[8*b +: 8];
      model[ea[6:3]] = word;
    end else begin
      eld = (word >> (8 * off)) & mask;
      ewb = fp || (idx != 5'd0);
      if (!fp && idx == 5'd0)
        chk(!wb_valid, "R7 zero destination suppressed", 64'(wb_valid), 64'h0);
      else
        chk(wb_valid == ewb, "R8 writeback valid", 64'(wb_valid), 64'(ewb));
      if (ewb) begin
        chk(wb_data == eld, "R4 load value", wb_data, eld);
        chk(wb_idx == idx && wb_fp == fp, "R8 writeback index and file",
            {wb_fp, wb_idx}, {fp, idx});
      end
    end
    @(negedge clk);
    chk(!done && !wb_valid, "R6 done single cycle", {done, wb_valid}, 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [5:0] ops [10];
    ops = '{6'h0c, 6'h0d, 6'h0e, 6'h0f, 6'h10, 6'h11, 6'h12, 6'h13, 6'h2a, 6'h2b};
    for (int i = 0; i < 16; i++)
      model[i] = 64'h0123456789ABCDEF ^ (64'(i) * 64'h1111_2222_3333_4444);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !mem_req && !done && !wb_valid && !misalign_err, "R10 reset state",
        {busy, mem_req, done, wb_valid, misalign_err}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    for (int oi = 0; oi < 10; oi++)
      for (int off = 0; off < 8; off++)
        for (int v = 0; v < 2; v++) begin
          logic [63:0] ea = 64'hA500_0000_0000_0100 + 64'(8 * ((oi + off + v) % 16)) + 64'(off);
          logic [15:0] imm = v ? 16'hFFE8 : 16'h0013;
          logic [63:0] dat = 64'hF1E2D3C4B5A69788 ^ (64'(oi * 8 + off) << (8 * v));
          logic [4:0]  idx = (off == 3 || (off == 0 && v == 1)) ? 5'd0 : 5'(off + 8 + v);
          run_op(ops[oi], ea, imm, dat, idx, (oi + off + v) % 3);
        end
    // R9: unlisted opcodes
    foreach (ops[k]) begin
      logic [5:0] bad = (k % 3 == 0) ? 6'h14 : (k % 3 == 1) ? 6'h01 : 6'h2c;
      issue_op = bad; issue_base = 64'h100; issue_imm = '0; issue_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      chk(!mem_req && !done && !misalign_err && !busy, "R9 unlisted opcode ignored",
          {mem_req, done, misalign_err, busy}, 64'h0);
      @(negedge clk);
      chk(!mem_req && !done, "R9 unlisted opcode stays idle", {mem_req, done}, 64'h0);
    end
    // R11: issue while busy
    issue_op = 6'h0f; issue_base = 64'h208; issue_imm = '0; issue_idx = 5'd4;
    issue_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue_op = 6'h10; issue_base = 64'h333; issue_data = 64'hFF;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(mem_req && !mem_we && mem_addr == 64'h208 && mem_be == 8'hFF,
        "R11 outstanding request unchanged", mem_addr, 64'h208);
    mem_ready = 1'b1; mem_rdata = 64'h1122334455667788;
    @(posedge clk);
    @(negedge clk);
    mem_ready = 1'b0;
    chk(done && wb_valid && wb_data == 64'h1122334455667788, "R11 first access completes",
        wb_data, 64'h1122334455667788);
    @(negedge clk);
    chk(!mem_req && !busy, "R11 no second request", {mem_req, busy}, 64'h0);
    // R10: reset mid-request
    issue_op = 6'h0e; issue_base = 64'h300; issue_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!busy && !mem_req && !done && !wb_valid, "R10 reset clears request",
        {busy, mem_req, done, wb_valid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule